// File: doc/BRIEF.md
# Per-Channel Overtemperature Trip Comparator

This block drives a shared active-low overtemperature output from three temperature channels: remote 1, local and remote 2. Each channel gets a new temperature sample once per monitoring cycle, marked by its own valid strobe. On that strobe the block compares the sample with the channel's critical limit. It then updates a per-channel trip state. The output pin is pulled low while any channel's trip state is set.

Trip and release use two thresholds. A channel trips when its sample is above the limit by at least one quarter degree, and it releases only once a sample is at or below the limit. Trip states change only on a strobe, so a trip lasts at least one full monitoring cycle.

A channel can be turned off in three ways: by its enable bit, by a limit low enough to count as "off" in the selected data format, or by the hysteresis-enable and global-disable controls set together. A channel that is turned off has its trip state cleared on the next clock.

Top module: `ovt_monitor`

## Requirements
- R1: On a channel's valid strobe, if the channel is active and its 10-bit sample is at least 4*limit + 1 in quarter-degree units, that channel's status bit reads 1 from the next clock. Both values are compared in the selected format's ordering. The sample's bits [9:2] are whole degrees in the same code as the limit, and bits [1:0] are quarter degrees.
- R2: On a valid strobe with a sample at or below 4*limit, the channel's status bit reads 0 from the next clock.
- R3: A status bit never changes on a clock without that channel's strobe, unless the channel is turned off. So a trip lasts at least one monitoring cycle.
- R4: Enable bit 0 selects remote 1, bit 1 selects local and bit 2 selects remote 2, in any combination. A disabled channel never trips, and its status is cleared on the next clock.
- R5: With fmt_twos=0 (offset format, code = degrees + 64), a limit code of 1 or less (-63 °C or lower) turns the channel off. A limit code of 2 does not.
- R6: With fmt_twos=1 (two's complement, signed order), a limit code of 0x80 (-128 °C) turns the channel off, and 0x81 does not.
- R7: While hyst_en and global_dis are both 1, no channel trips and all status bits are cleared on the next clock. Either bit set alone has no effect.
- R8: ovt_n is low exactly when any status bit is 1. After reset, all status bits are 0 and ovt_n is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid | input | 3 | Per-channel sample strobe (bit 0 remote 1, bit 1 local, bit 2 remote 2) |
| samp_temp | input | 30 | Samples; channel i in bits [10i+9:10i] |
| crit_lim | input | 24 | Limits; channel i in bits [8i+7:8i] |
| ch_en | input | 3 | Per-channel trip enables |
| global_dis | input | 1 | Global trip disable (acts together with hyst_en) |
| hyst_en | input | 1 | Hysteresis enable |
| fmt_twos | input | 1 | 1 = two's complement, 0 = offset-64 format |
| ovt_n | output | 1 | Active-low overtemperature pin drive |
| ch_hot | output | 3 | Per-channel trip status |

## Verification
On every cycle, the assertions check that a status bit rises only after that channel's strobe, and that a disabled channel, an "off" limit code in either format, or the combined inhibit clears status on the next clock. The arithmetic cannot be seen by a property without restating the design, so only the bench's scenarios show it. That covers the quarter-degree trip margin, the release exactly at the limit, the signed ordering of negative samples against positive limits in two's-complement format, and the boundary limit codes that are just above the off threshold.

// File: rtl/ovt_pkg.sv
package ovt_pkg;

   typedef enum logic {
      FMT_OFFSET = 1'b0,
      FMT_TWOS   = 1'b1
   } temp_fmt_e;

   typedef struct packed {
      logic trip;     // sample clears the set threshold
      logic clear;    // sample at or below the limit
      logic lim_off;  // limit code means "channel off"
   } ch_eval_t;

endpackage

// File: rtl/ovt_thresh.sv
module ovt_thresh
   import ovt_pkg::*;
#(
   parameter int LIM_W       = 8,
   parameter int FRAC_W      = 2,
   parameter int MARGIN_Q    = 1,
   parameter int OFF_DIS_MAX = 1
) (
   input  logic [LIM_W+FRAC_W-1:0] temp,
   input  logic [LIM_W-1:0]        lim,
   input  temp_fmt_e               fmt,
   output ch_eval_t                eval
);
   localparam int TW  = LIM_W + FRAC_W;
   localparam int CW  = TW + 1;

   logic [TW-1:0]    t_key;
   logic [LIM_W-1:0] l_key;
   logic [CW-1:0]    lim_q;
   logic [CW-1:0]    set_q;

   // Map both formats onto an unsigned ordering.
   always_comb begin
      if (fmt == FMT_TWOS) begin
         t_key = {~temp[TW-1], temp[TW-2:0]};
         l_key = {~lim[LIM_W-1], lim[LIM_W-2:0]};
      end else begin
         t_key = temp;
         l_key = lim;
      end
      lim_q = {1'b0, l_key, {FRAC_W{1'b0}}};
      set_q = lim_q + CW'(MARGIN_Q);
   end

   always_comb begin
      eval.trip  = {1'b0, t_key} >= set_q;
      eval.clear = {1'b0, t_key} <= lim_q;
      if (fmt == FMT_TWOS)
         eval.lim_off = (l_key == '0);
      else
         eval.lim_off = (lim <= LIM_W'(OFF_DIS_MAX));
   end

endmodule

// File: rtl/ovt_chan_state.sv
module ovt_chan_state
   import ovt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active,
   input  logic     strobe,
   input  ch_eval_t eval,
   output logic     hot
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         hot <= 1'b0;
      else if (!active)
         hot <= 1'b0;
      else if (strobe) begin
         if (eval.trip)
            hot <= 1'b1;
         else if (eval.clear)
            hot <= 1'b0;
      end
   end
endmodule

// File: rtl/ovt_monitor.sv
module ovt_monitor
   import ovt_pkg::*;
#(
   parameter int NUM_CH      = 3,
   parameter int LIM_W       = 8,
   parameter int FRAC_W      = 2,
   parameter int MARGIN_Q    = 1,
   parameter int OFFSET_BIAS = 64,
   parameter int OFF_DIS_C   = -63,
   parameter bit REG_PIN     = 1'b0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CH-1:0]               samp_valid,
   input  logic [NUM_CH*(LIM_W+FRAC_W)-1:0] samp_temp,
   input  logic [NUM_CH*LIM_W-1:0]         crit_lim,
   input  logic [NUM_CH-1:0]               ch_en,
   input  logic                            global_dis,
   input  logic                            hyst_en,
   input  logic                            fmt_twos,
   output logic                            ovt_n,
   output logic [NUM_CH-1:0]               ch_hot
);
   localparam int TW          = LIM_W + FRAC_W;
   localparam int OFF_DIS_MAX = OFF_DIS_C + OFFSET_BIAS;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (LIM_W < 2 || FRAC_W < 1) begin : g_bad_w
      $error("LIM_W must be >= 2 and FRAC_W >= 1");
   end
   if (MARGIN_Q < 1 || MARGIN_Q >= (1 << FRAC_W) * 4) begin : g_bad_m
      $error("MARGIN_Q out of range");
   end
   if (OFF_DIS_MAX < 0 || OFF_DIS_MAX >= (1 << LIM_W)) begin : g_bad_off
      $error("offset-format off threshold does not fit the limit width");
   end

   temp_fmt_e fmt;
   logic      inhibit;

   assign fmt     = fmt_twos ? FMT_TWOS : FMT_OFFSET;
   assign inhibit = hyst_en & global_dis;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ch_eval_t eval;

      ovt_thresh #(
         .LIM_W      (LIM_W),
         .FRAC_W     (FRAC_W),
         .MARGIN_Q   (MARGIN_Q),
         .OFF_DIS_MAX(OFF_DIS_MAX)
      ) u_thresh (
         .temp (samp_temp[i*TW +: TW]),
         .lim  (crit_lim[i*LIM_W +: LIM_W]),
         .fmt  (fmt),
         .eval (eval)
      );

      ovt_chan_state u_state (
         .clk    (clk),
         .rst_n  (rst_n),
         .active (ch_en[i] & ~eval.lim_off & ~inhibit),
         .strobe (samp_valid[i]),
         .eval   (eval),
         .hot    (ch_hot[i])
      );
   end

   if (REG_PIN) begin : g_pin_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            ovt_n <= 1'b1;
         else
            ovt_n <= ~|ch_hot;
      end
   end else begin : g_pin_comb
      assign ovt_n = ~|ch_hot;
   end

endmodule

// File: rtl/ovt_monitor_chk.sv
module ovt_monitor_chk #(
   parameter int NUM_CH      = 3,
   parameter int LIM_W       = 8,
   parameter int FRAC_W      = 2,
   parameter int OFFSET_BIAS = 64,
   parameter int OFF_DIS_C   = -63
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic [NUM_CH-1:0]                samp_valid,
   input logic [NUM_CH*LIM_W-1:0]          crit_lim,
   input logic [NUM_CH-1:0]                ch_en,
   input logic                             global_dis,
   input logic                             hyst_en,
   input logic                             fmt_twos,
   input logic [NUM_CH-1:0]                ch_hot
);
   localparam int OFF_MAX = OFF_DIS_C + OFFSET_BIAS;
   localparam logic [LIM_W-1:0] TWOS_MIN = {1'b1, {(LIM_W-1){1'b0}}};

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      logic [LIM_W-1:0] lim_i;
      assign lim_i = crit_lim[i*LIM_W +: LIM_W];

      AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(ch_hot[i]) |-> $past(samp_valid[i]));                     // R3
      AST_EN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_en[i] |=> !ch_hot[i]);                                        // R4
      AST_OFFSET_LOWLIM: assert property (@(posedge clk) disable iff (!rst_n)
         (!fmt_twos && lim_i <= LIM_W'(OFF_MAX)) |=> !ch_hot[i]);          // R5
      AST_TWOS_LOWLIM: assert property (@(posedge clk) disable iff (!rst_n)
         (fmt_twos && lim_i == TWOS_MIN) |=> !ch_hot[i]);                  // R6
   end

   AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (hyst_en && global_dis) |=> (ch_hot == '0));                        // R7

endmodule

bind ovt_monitor ovt_monitor_chk #(
   .NUM_CH     (NUM_CH),
   .LIM_W      (LIM_W),
   .FRAC_W     (FRAC_W),
   .OFFSET_BIAS(OFFSET_BIAS),
   .OFF_DIS_C  (OFF_DIS_C)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_valid(samp_valid),
   .crit_lim  (crit_lim),
   .ch_en     (ch_en),
   .global_dis(global_dis),
   .hyst_en   (hyst_en),
   .fmt_twos  (fmt_twos),
   .ch_hot    (ch_hot)
);

// File: tb/ovt_monitor_test.sv
module ovt_monitor_test;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  samp_valid = '0;
   logic [29:0] samp_temp = '0;
   logic [23:0] crit_lim = {8'd100, 8'd100, 8'd100};
   logic [2:0]  ch_en = 3'b111;
   logic        global_dis = 1'b0;
   logic        hyst_en = 1'b0;
   logic        fmt_twos = 1'b0;
   logic        ovt_n;
   logic [2:0]  ch_hot;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // {ch[1:0], fmt, lim[7:0], temp[9:0], expected status[2:0]}
   localparam logic [23:0] VECS [NV] = '{
      {2'd0, 1'b0, 8'd100,  10'd400,   3'b000},  // R1 at limit: no trip
      {2'd0, 1'b0, 8'd100,  10'd401,   3'b001},  // R1 +0.25
      {2'd1, 1'b0, 8'd100,  10'd300,   3'b001},
      {2'd0, 1'b0, 8'd100,  10'd400,   3'b000},  // R2 release at limit
      {2'd2, 1'b0, 8'd50,   10'd201,   3'b100},
      {2'd1, 1'b0, 8'd20,   10'd1023,  3'b110},
      {2'd2, 1'b0, 8'd50,   10'd200,   3'b010},  // R2
      {2'd1, 1'b0, 8'd20,   10'd80,    3'b000},
      {2'd0, 1'b1, 8'hF6,   10'h3D8,   3'b000},  // R6 -10.00 vs -10
      {2'd0, 1'b1, 8'hF6,   10'h3D9,   3'b001},  // R6 -9.75
      {2'd0, 1'b1, 8'hF6,   10'h010,   3'b001},  // R6 positive sample
      {2'd0, 1'b1, 8'hF6,   10'h3D8,   3'b000},
      {2'd1, 1'b1, 8'd5,    10'h3FF,   3'b000},  // R6 -0.25 vs +5
      {2'd1, 1'b1, 8'd5,    10'h015,   3'b010}   // R6 5.25 vs 5
   };

   ovt_monitor uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_valid(samp_valid),
      .samp_temp (samp_temp),
      .crit_lim  (crit_lim),
      .ch_en     (ch_en),
      .global_dis(global_dis),
      .hyst_en   (hyst_en),
      .fmt_twos  (fmt_twos),
      .ovt_n     (ovt_n),
      .ch_hot    (ch_hot)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [2:0] exp);
      n_chk++;
      if (ch_hot !== exp || ovt_n !== ~|exp) begin
         n_fail++;
         $display("FAIL %s: status=%b ovt_n=%b expected status=%b ovt_n=%b",
                  req, ch_hot, ovt_n, exp, ~|exp);
      end
   endtask

   task automatic put_temp(input int ch, input logic [9:0] t);
      samp_temp[ch*10 +: 10] = t;
   endtask

   task automatic strobe(input int ch, input logic [9:0] t);
      @(negedge clk);
      put_temp(ch, t);
      samp_valid = 3'b001 << ch;
      @(posedge clk);
      @(negedge clk);
      samp_valid = '0;
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run hung");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // table walk
      for (int v = 0; v < NV; v++) begin
         logic [23:0] w;
         w = VECS[v];
         @(negedge clk);
         fmt_twos = w[21];
         crit_lim[int'(w[23:22])*8 +: 8] = w[20:13];
         strobe(int'(w[23:22]), w[12:3]);
         check($sformatf("R1/R2 vector %0d", v), w[2:0]);
      end

      // reset state (R8)
      @(negedge clk);
      rst_n = 1'b0;
      fmt_twos = 1'b0;
      crit_lim = {8'd100, 8'd100, 8'd100};
      samp_temp = '0;
      idle(2);
      rst_n = 1'b1;
      check("R8 reset", 3'b000);

      // R3: no strobe, no change
      put_temp(0, 10'd1023);
      idle(3);
      check("R3 hot sample without strobe", 3'b000);
      strobe(0, 10'd1023);
      check("R1 trip on strobe", 3'b001);
      put_temp(0, 10'd0);
      idle(4);
      check("R3 hold between strobes", 3'b001);
      strobe(0, 10'd0);
      check("R2 release on strobe", 3'b000);

      // R4 enables
      ch_en = 3'b101;
      strobe(1, 10'd1023);
      check("R4 disabled local", 3'b000);
      ch_en = 3'b111;
      strobe(2, 10'd1023);
      check("R4 remote 2 trips", 3'b100);
      ch_en = 3'b011;
      idle(1);
      check("R4 disable clears", 3'b000);
      ch_en = 3'b111;
      strobe(2, 10'd0);

      // R5 offset low limit
      crit_lim[7:0] = 8'd1;
      strobe(0, 10'd1023);
      check("R5 limit code 1 off", 3'b000);
      crit_lim[7:0] = 8'd2;
      strobe(0, 10'd1023);
      check("R5 limit code 2 active", 3'b001);
      crit_lim[7:0] = 8'd100;
      strobe(0, 10'd0);

      // R6 twos low limit
      fmt_twos = 1'b1;
      crit_lim[7:0] = 8'h80;
      strobe(0, 10'h1FF);
      check("R6 limit 0x80 off", 3'b000);
      crit_lim[7:0] = 8'h81;
      strobe(0, 10'h1FF);
      check("R6 limit 0x81 active", 3'b001);
      crit_lim[7:0] = 8'd100;
      strobe(0, 10'd0);
      fmt_twos = 1'b0;
      check("R2 twos release", 3'b000);

      // R7 inhibit
      hyst_en = 1'b1;
      global_dis = 1'b1;
      strobe(0, 10'd1023);
      check("R7 both set blocks trip", 3'b000);
      hyst_en = 1'b0;
      strobe(0, 10'd1023);
      check("R7 global_dis alone no effect", 3'b001);
      hyst_en = 1'b1;
      idle(1);
      check("R7 inhibit clears", 3'b000);
      global_dis = 1'b0;
      strobe(1, 10'd1023);
      check("R7 hyst_en alone no effect", 3'b010);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule